// File: doc/BRIEF.md
# PLL Lock Supervisor with Fastlock Sequencing

This block works out whether a slow, reference-tracking primary PLL is in lock. It watches two things: a strobe that marks each reference line, and a digitized sample of the loop-filter control voltage taken at that line. A line whose control-voltage sample has moved by no more than a programmed step tolerance since the previous line counts as good. A line that moved further counts as bad. A line that never arrives within a programmed number of system clocks counts as missing. A run of good lines declares lock. Lock is dropped only after a programmable count of bad or missing lines, so short gaps in the reference leave the lock status alone. Gaps of this kind are normal during vertical blanking.

The primary status is merged with the lock flags of three secondary PLLs into four per-PLL no-lock bits. It also drives one active-high combined no-lock output. In that output, any PLL that is masked or powered down is left out. The block also controls the primary loop's charge-pump boost. The boost is on while the loop is unlocked, so that lock is reached quickly. After lock is declared, it stays on for a programmed number of clocks before dropping back to normal current.

Top module: `pll_lock_supervisor`

## Requirements
- R1: `pll_nolock[0]` is the inverse of the registered primary lock state. `pll_nolock[i]` for i = 1..3 is the combinational inverse of `sec_locked[i-1]`.
- R2: A line strobe is good when |`cv_sample` − previous sampled value| <= `step_tol`, and bad otherwise. The first strobe after reset only records its sample and is neither good nor bad.
- R3: While unlocked, the fourth consecutive good line declares lock. `pll_nolock[0]` falls on the clock edge that samples that strobe. A bad or missing line restarts the run of good lines.
- R4: While locked, each bad or missing line increments a loss count and each good line clears it. Lock is dropped on the edge where the count reaches `loss_thresh`. A threshold of 0 behaves as 1.
- R5: A missing line is declared when `miss_timeout` clocks pass with no strobe since the last strobe or the last missing event. The first such event comes on the edge `miss_timeout` clocks after the strobe. A `miss_timeout` of 0 disables the detection.
- R6: `nolock_any` is the OR of `pll_nolock[i]` over every i whose `lock_mask[i]` is 0 and whose `pll_pd[i]` is 0. The output is combinational.
- R7: When `fastlock_en` is 1 and the primary is unlocked, `cp_boost` is 1. When `fastlock_en` is 0, `cp_boost` is 0.
- R8: After lock is declared at edge E, `cp_boost` stays 1 through edge E+`boost_delay` and drops to 0 at edge E+`boost_delay`+1.
- R9: If lock is lost while that hold time is still running, `cp_boost` returns to 1 in the same cycle. The next lock starts a full new hold time.
- R10: Synchronous active-high `rst` forces the primary to unlocked, sets `cp_boost` (when `fastlock_en` is 1) and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle strobe per reference line |
| cv_sample | input | CV_W | Control-voltage sample valid with line_stb |
| sec_locked | input | N_PLL-1 | Lock flags from secondary PLLs |
| pll_pd | input | N_PLL | Per-PLL power-down flags |
| step_tol | input | CV_W | Allowed sample change per line |
| loss_thresh | input | LOSS_W | Bad/missing lines needed to drop lock |
| miss_timeout | input | TO_W | Clocks without a strobe that make one missing line |
| lock_mask | input | N_PLL | Per-PLL exclusion from nolock_any |
| fastlock_en | input | 1 | Enables charge-pump boost |
| boost_delay | input | DLY_W | Boost hold time after lock, in clocks |
| pll_nolock | output | N_PLL | Per-PLL no-lock bits |
| nolock_any | output | 1 | Masked OR of the no-lock bits |
| cp_boost | output | 1 | Boosted charge-pump current select |

## Verification
A wrong count of good lines shows at `pll_nolock[0]` on the very edge that samples the fourth good strobe. A wrong loss count shows on the edge where the threshold should or should not have been reached. A timer that is off by even one clock moves the edge at which a lock drop appears after a gap, so the bench samples half a cycle on each side of it. A hold counter that is not restarted after a lost lock keeps `cp_boost` low too early after relock, which is visible within about a dozen clocks.

// File: rtl/lsv_pkg.sv
package lsv_pkg;
   typedef enum logic {
      PRI_UNLOCKED = 1'b0,
      PRI_LOCKED   = 1'b1
   } pri_state_e;

   localparam int unsigned GOOD_RUN = 4;
   localparam int unsigned RUN_W    = $clog2(GOOD_RUN);
endpackage

// File: rtl/lsv_pulse_judge.sv
module lsv_pulse_judge #(
   parameter int unsigned CV_W          = 12,
   parameter int unsigned TO_W          = 16,
   parameter bit          TOL_INCLUSIVE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            line_stb,
   input  logic [CV_W-1:0] cv_sample,
   input  logic [CV_W-1:0] step_tol,
   input  logic [TO_W-1:0] miss_timeout,
   output logic            good_evt,
   output logic            bad_evt,
   output logic            miss_evt
);
   localparam logic [TO_W-1:0] TIMER_MAX = '1;

   logic [CV_W-1:0] prev_cv;
   logic            prev_valid;
   logic [TO_W-1:0] idle_timer;
   logic [CV_W-1:0] delta;
   logic            within_tol;

   always_comb begin
      if (cv_sample >= prev_cv) delta = cv_sample - prev_cv;
      else                      delta = prev_cv - cv_sample;
   end

   generate
      if (TOL_INCLUSIVE) begin : g_incl
         assign within_tol = (delta <= step_tol);
      end else begin : g_excl
         assign within_tol = (delta < step_tol);
      end
   endgenerate

   assign good_evt = line_stb && prev_valid && within_tol;
   assign bad_evt  = line_stb && prev_valid && !within_tol;
   assign miss_evt = !line_stb && (miss_timeout != '0) &&
                     (idle_timer == miss_timeout - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_cv    <= '0;
         prev_valid <= 1'b0;
         idle_timer <= '0;
      end else begin
         if (line_stb) begin
            prev_cv    <= cv_sample;
            prev_valid <= 1'b1;
         end
         if (line_stb || miss_evt)         idle_timer <= '0;
         else if (idle_timer != TIMER_MAX) idle_timer <= idle_timer + 1'b1;
      end
   end

   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({good_evt, bad_evt, miss_evt})); // R2
endmodule

// File: rtl/lsv_lock_fsm.sv
module lsv_lock_fsm
   import lsv_pkg::*;
#(
   parameter int unsigned LOSS_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              good_evt,
   input  logic              bad_evt,
   input  logic              miss_evt,
   input  logic [LOSS_W-1:0] loss_thresh,
   output logic              locked
);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);

   pri_state_e        state;
   logic [RUN_W-1:0]  good_run;
   logic [LOSS_W-1:0] loss_cnt;
   logic [LOSS_W:0]   loss_next;
   logic              fault_evt;

   assign fault_evt = bad_evt || miss_evt;
   assign loss_next = {1'b0, loss_cnt} + 1'b1;
   assign locked    = (state == PRI_LOCKED);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= PRI_UNLOCKED;
         good_run <= '0;
         loss_cnt <= '0;
      end else begin
         unique case (state)
            PRI_UNLOCKED: begin
               loss_cnt <= '0;
               if (fault_evt) good_run <= '0;
               else if (good_evt) begin
                  if (good_run == RUN_LAST) begin
                     state    <= PRI_LOCKED;
                     good_run <= '0;
                  end else begin
                     good_run <= good_run + 1'b1;
                  end
               end
            end
            PRI_LOCKED: begin
               good_run <= '0;
               if (good_evt) loss_cnt <= '0;
               else if (fault_evt) begin
                  if (loss_next >= {1'b0, loss_thresh}) begin
                     state    <= PRI_UNLOCKED;
                     loss_cnt <= '0;
                  end else begin
                     loss_cnt <= loss_next[LOSS_W-1:0];
                  end
               end
            end
            default: state <= PRI_UNLOCKED;
         endcase
      end
   end

   AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(good_evt)); // R3
   AST_UNLOCK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> $past(bad_evt || miss_evt)); // R4
endmodule

// File: rtl/lsv_boost_ctrl.sv
module lsv_boost_ctrl #(
   parameter int unsigned DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             locked,
   input  logic             fastlock_en,
   input  logic [DLY_W-1:0] boost_delay,
   output logic             cp_boost
);
   logic             hold;
   logic [DLY_W-1:0] hold_cnt;

   always_ff @(posedge clk) begin
      if (rst || !locked) begin
         hold     <= 1'b1;
         hold_cnt <= '0;
      end else if (hold) begin
         if (hold_cnt == boost_delay) hold <= 1'b0;
         else                         hold_cnt <= hold_cnt + 1'b1;
      end
   end

   assign cp_boost = fastlock_en && (hold || !locked);

   AST_BOOST_DROPS_LOCKED: assert property (@(posedge clk) disable iff (rst)
      ($fell(cp_boost) && $past(fastlock_en) && fastlock_en) |-> locked); // R8
   AST_BOOST_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
      !fastlock_en |-> !cp_boost); // R7
endmodule

// File: rtl/lsv_nolock_merge.sv
module lsv_nolock_merge #(
   parameter int unsigned N_PLL = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pri_locked,
   input  logic [N_PLL-2:0] sec_locked,
   input  logic [N_PLL-1:0] lock_mask,
   input  logic [N_PLL-1:0] pll_pd,
   output logic [N_PLL-1:0] pll_nolock,
   output logic             nolock_any
);
   logic [N_PLL-1:0] visible;

   assign pll_nolock[0] = !pri_locked;

   generate
      for (genvar i = 1; i < N_PLL; i++) begin : g_sec
         assign pll_nolock[i] = !sec_locked[i-1];
      end
      for (genvar j = 0; j < N_PLL; j++) begin : g_vis
         assign visible[j] = pll_nolock[j] && !lock_mask[j] && !pll_pd[j];
      end
   endgenerate

   assign nolock_any = |visible;

   AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (rst)
      (&(lock_mask | pll_pd)) |-> !nolock_any); // R6
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor #(
   parameter int unsigned N_PLL         = 4,
   parameter int unsigned CV_W          = 12,
   parameter int unsigned LOSS_W        = 4,
   parameter int unsigned TO_W          = 16,
   parameter int unsigned DLY_W         = 16,
   parameter bit          TOL_INCLUSIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_stb,
   input  logic [CV_W-1:0]   cv_sample,
   input  logic [N_PLL-2:0]  sec_locked,
   input  logic [N_PLL-1:0]  pll_pd,
   input  logic [CV_W-1:0]   step_tol,
   input  logic [LOSS_W-1:0] loss_thresh,
   input  logic [TO_W-1:0]   miss_timeout,
   input  logic [N_PLL-1:0]  lock_mask,
   input  logic              fastlock_en,
   input  logic [DLY_W-1:0]  boost_delay,
   output logic [N_PLL-1:0]  pll_nolock,
   output logic              nolock_any,
   output logic              cp_boost
);
   generate
      if (N_PLL < 2)  begin : g_bad_npll $error("N_PLL must be at least 2"); end
      if (CV_W < 2)   begin : g_bad_cv   $error("CV_W must be at least 2"); end
      if (LOSS_W < 1) begin : g_bad_loss $error("LOSS_W must be at least 1"); end
      if (TO_W < 2)   begin : g_bad_to   $error("TO_W must be at least 2"); end
      if (DLY_W < 1)  begin : g_bad_dly  $error("DLY_W must be at least 1"); end
   endgenerate

   logic good_evt, bad_evt, miss_evt, pri_locked;

   lsv_pulse_judge #(.CV_W(CV_W), .TO_W(TO_W), .TOL_INCLUSIVE(TOL_INCLUSIVE)) u_judge (
      .clk(clk), .rst(rst), .line_stb(line_stb), .cv_sample(cv_sample),
      .step_tol(step_tol), .miss_timeout(miss_timeout),
      .good_evt(good_evt), .bad_evt(bad_evt), .miss_evt(miss_evt));

   lsv_lock_fsm #(.LOSS_W(LOSS_W)) u_fsm (
      .clk(clk), .rst(rst), .good_evt(good_evt), .bad_evt(bad_evt),
      .miss_evt(miss_evt), .loss_thresh(loss_thresh), .locked(pri_locked));

   lsv_boost_ctrl #(.DLY_W(DLY_W)) u_boost (
      .clk(clk), .rst(rst), .locked(pri_locked), .fastlock_en(fastlock_en),
      .boost_delay(boost_delay), .cp_boost(cp_boost));

   lsv_nolock_merge #(.N_PLL(N_PLL)) u_merge (
      .clk(clk), .rst(rst), .pri_locked(pri_locked), .sec_locked(sec_locked),
      .lock_mask(lock_mask), .pll_pd(pll_pd),
      .pll_nolock(pll_nolock), .nolock_any(nolock_any));

   AST_BOOST_WHILE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
      (fastlock_en && pll_nolock[0]) |-> cp_boost); // R7
endmodule

// File: tb/pll_lock_supervisor_bench.sv
module pll_lock_supervisor_bench;
   localparam int CV_W = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        line_stb = 1'b0;
   logic [11:0] cv_sample = '0;
   logic [2:0]  sec_locked = 3'b111;
   logic [3:0]  pll_pd = '0;
   logic [11:0] step_tol = 12'd8;
   logic [3:0]  loss_thresh = 4'd3;
   logic [15:0] miss_timeout = 16'd1000;
   logic [3:0]  lock_mask = '0;
   logic        fastlock_en = 1'b1;
   logic [15:0] boost_delay = 16'd1000;
   logic [3:0]  pll_nolock;
   logic        nolock_any;
   logic        cp_boost;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pll_lock_supervisor u_pll_lock_supervisor (
      .clk(clk), .rst(rst), .line_stb(line_stb), .cv_sample(cv_sample),
      .sec_locked(sec_locked), .pll_pd(pll_pd), .step_tol(step_tol),
      .loss_thresh(loss_thresh), .miss_timeout(miss_timeout),
      .lock_mask(lock_mask), .fastlock_en(fastlock_en),
      .boost_delay(boost_delay), .pll_nolock(pll_nolock),
      .nolock_any(nolock_any), .cp_boost(cp_boost));

   // {expected pll_nolock[0] after the strobe, cv sample}
   localparam logic [CV_W:0] VEC [16] = '{
      {1'b1, 12'd100}, {1'b1, 12'd104}, {1'b1, 12'd100}, {1'b1, 12'd108},
      {1'b0, 12'd116}, {1'b0, 12'd200}, {1'b0, 12'd205}, {1'b0, 12'd300},
      {1'b0, 12'd400}, {1'b1, 12'd500}, {1'b1, 12'd505}, {1'b1, 12'd600},
      {1'b1, 12'd601}, {1'b1, 12'd602}, {1'b1, 12'd603}, {1'b0, 12'd604}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; line_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] cv, input int gap);
      @(negedge clk); line_stb = 1'b1; cv_sample = cv;
      @(negedge clk); line_stb = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_lock(input logic [11:0] base);
      for (int k = 0; k < 5; k++) pulse(base + 12'(k), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R10 reset state
      do_reset();
      #1;
      check("R10 primary nolock after reset", 32'(pll_nolock[0]), 32'd1);
      check("R10 boost after reset", 32'(cp_boost), 32'd1);
      check("R1 secondaries locked", 32'(pll_nolock[3:1]), 32'd0);

      // Table walk: R2 R3 R4
      for (int i = 0; i < 16; i++) begin
         pulse(VEC[i][CV_W-1:0], 3);
         check($sformatf("R3/R4 vector %0d", i), 32'(pll_nolock[0]), 32'(VEC[i][CV_W]));
      end

      // R6 / R1 masking and power-down
      do_reset();
      sec_locked = 3'b111; lock_mask = '0; pll_pd = '0; #1;
      check("R6 unmasked primary", 32'(nolock_any), 32'd1);
      pll_pd = 4'b0001; #1;
      check("R6 primary powered down", 32'(nolock_any), 32'd0);
      pll_pd = '0; lock_mask = 4'b0001; #1;
      check("R6 primary masked", 32'(nolock_any), 32'd0);
      sec_locked = 3'b101; #1;
      check("R1 secondary bit map", 32'(pll_nolock), 32'h5);
      check("R6 secondary visible", 32'(nolock_any), 32'd1);
      lock_mask = 4'b0101; #1;
      check("R6 secondary masked", 32'(nolock_any), 32'd0);
      lock_mask = 4'b0001; pll_pd = 4'b0100; #1;
      check("R6 secondary powered down", 32'(nolock_any), 32'd0);
      sec_locked = 3'b111; lock_mask = '0; pll_pd = '0;

      // R7 boost disabled
      fastlock_en = 1'b0; #1;
      check("R7 boost off when disabled", 32'(cp_boost), 32'd0);
      fastlock_en = 1'b1; #1;
      check("R7 boost on while unlocked", 32'(cp_boost), 32'd1);

      // R8 hold time
      do_reset();
      boost_delay = 16'd5;
      do_lock(12'd100);
      check("R8 locked", 32'(pll_nolock[0]), 32'd0);
      check("R8 boost at lock", 32'(cp_boost), 32'd1);
      repeat (5) @(negedge clk);
      check("R8 boost at E+delay", 32'(cp_boost), 32'd1);
      @(negedge clk);
      check("R8 boost dropped", 32'(cp_boost), 32'd0);

      // R9 loss while hold runs
      do_reset();
      boost_delay = 16'd20; loss_thresh = 4'd3;
      do_lock(12'd100);
      repeat (8) @(negedge clk);
      pulse(12'd500, 0); pulse(12'd900, 0); pulse(12'd1300, 0);
      check("R9 unlocked", 32'(pll_nolock[0]), 32'd1);
      check("R9 boost back on", 32'(cp_boost), 32'd1);
      for (int k = 1; k < 5; k++) pulse(12'd1300 + 12'(k), 0);
      check("R9 relocked", 32'(pll_nolock[0]), 32'd0);
      repeat (12) @(negedge clk);
      check("R9 hold restarted", 32'(cp_boost), 32'd1);
      repeat (10) @(negedge clk);
      check("R9 hold expired", 32'(cp_boost), 32'd0);

      // R5 missing lines, threshold 2
      do_reset();
      miss_timeout = 16'd10; loss_thresh = 4'd2;
      do_lock(12'd50);
      repeat (19) @(negedge clk);
      check("R5 one miss tolerated", 32'(pll_nolock[0]), 32'd0);
      @(negedge clk);
      check("R5 second miss drops lock", 32'(pll_nolock[0]), 32'd1);

      // R4 threshold 0 behaves as 1
      do_reset();
      miss_timeout = 16'd0; loss_thresh = 4'd0;
      do_lock(12'd50);
      repeat (30) @(negedge clk);
      check("R5 timeout 0 disables misses", 32'(pll_nolock[0]), 32'd0);
      pulse(12'd900, 0);
      check("R4 zero threshold drops at once", 32'(pll_nolock[0]), 32'd1);

      finish_run();
   end
endmodule